// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Port

This block is a clocked read port onto a 24 Mbit mask-style read-only array. A mode input selects how the array is organised. In word mode it reads as 1,572,864 words of 16 bits. In byte mode it reads as 3,145,728 bytes of 8 bits. In byte mode, one shared pin stops being data bit 15 and becomes an extra address bit below A0. That bit picks which half of the addressed word reaches the low data lane.

The data lanes are modelled as plain buses, each with its own enable flag, so the block stays synthesizable. There are three enables: the low lane (bits 0-7), the high lane (bits 8-14) and the shared bit 15. An enable that is low means the lane is in high impedance.

The enables can be cleared in three ways:
- Chip-enable high puts the part in standby.
- Output-enable high switches the outputs off while the part stays in operating mode.
- An address in the top quarter of the space, where the two highest address bits are both high, is treated as holding no data.

Array contents are computed from the word address by a fixed function, so no file is needed. All outputs are registered once, which gives one cycle of latency.

Top module: `rom_rp_top`

## Requirements
- R1: Word mode (word_mode=1), with a populated address selected and ce_n=0, oe_n=0: one clock later dlo_o=W[7:0], dhi_o=W[14:8] and d15_o=W[15], and dlo_oe, dhi_oe and d15_oe are all 1. W is the word at address addr, and a_m1_in has no effect.
- R2: Byte mode (word_mode=0) with a_m1_in=0 and a populated read: one clock later dlo_o=W[7:0] and dlo_oe=1, while dhi_oe=0 and d15_oe=0.
- R3: Byte mode with a_m1_in=1 and a populated read: one clock later dlo_o=W[15:8] and dlo_oe=1, while dhi_oe=0 and d15_oe=0.
- R4: While ce_n=1, one clock later standby=1 and all three lane enables are 0, whatever the values of oe_n, word_mode and addr.
- R5: With ce_n=0 and oe_n=1, one clock later all three lane enables are 0 and standby=0.
- R6: When the two top address bits are both 1, one clock later all three lane enables are 0 in either mode, with standby=0.
- R7: Outputs change only at a rising clock edge. After an input change, the old result stays on the outputs until the next edge.
- R8: While rst_n is low, and until it has been seen high at two clock edges, all lane enables are 0 and standby=1.
- R9: The stored word is W = H[31:16] XOR H[15:0], where H = (word address zero-extended to 32 bits) × 0x9E3779B1, taken modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 selects 16-bit word reads, 0 selects byte reads |
| addr | input | ADDR_W | Word address A0 upward |
| a_m1_in | input | 1 | Shared pin used as the byte-select address bit in byte mode |
| dlo_o | output | 8 | Low data lane (bits 0-7) |
| dlo_oe | output | 1 | Low lane driven when 1 |
| dhi_o | output | 7 | High data lane (bits 8-14) |
| dhi_oe | output | 1 | High lane driven when 1 |
| d15_o | output | 1 | Shared pin as data bit 15 |
| d15_oe | output | 1 | Shared pin driven as output when 1 |
| standby | output | 1 | 1 while the part is in standby |

## Verification
Embedded properties check the gating rules on every cycle:
- standby silences every lane;
- output-enable high silences every lane without entering standby;
- the unpopulated region yields no driven lane;
- byte mode never drives the high lane or the shared pin;
- the high lane is never driven without the low lane.

The data values themselves only show up in the bench. It sweeps every word address of a 6-bit configuration in both modes and with both byte selects, and compares each read against the content formula computed on its own side. The bench scenarios also cover the one-cycle latency, the behaviour during reset, and the way a_m1_in is ignored in word mode.

// File: rtl/rom_rp_pkg.sv
package rom_rp_pkg;

  localparam logic [31:0] HASH_K = 32'h9E3779B1;

  // Registered lane state presented at the block's ports.
  typedef struct packed {
    logic       standby;
    logic       lo_en;
    logic       hi_en;
    logic       b15_en;
    logic [7:0] lo;
    logic [6:0] hi;
    logic       b15;
  } lane_out_t;

  // Content function: multiplicative hash of the word address, folded to 16 bits.
  function automatic logic [15:0] mix_word(input logic [31:0] a);
    logic [31:0] h;
    h = a * HASH_K;
    return h[31:16] ^ h[15:0];
  endfunction

endpackage

// File: rtl/rom_rp_decode.sv
module rom_rp_decode #(
  parameter int ADDR_W = 21
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              a_m1,
  input  logic              word_mode,
  output logic [ADDR_W-1:0] word_addr,
  output logic              hole,
  output logic              sel_hi
);

  localparam int TOP = ADDR_W - 1;

  always_comb begin
    word_addr = addr;
    // The top quarter (two highest bits both set) holds no data.
    hole      = addr[TOP] & addr[TOP-1];
    // The shared pin only acts as an address bit in byte mode.
    sel_hi    = ~word_mode & a_m1;
  end

endmodule

// File: rtl/rom_rp_array.sv
module rom_rp_array #(
  parameter int ADDR_W = 21,
  parameter int WORD_W = 16
) (
  input  logic [ADDR_W-1:0] word_addr,
  output logic [WORD_W-1:0] word
);
  import rom_rp_pkg::*;

  logic [31:0] a32;

  generate
    if (ADDR_W > 32 || WORD_W != 16) begin : g_bad_cfg
      initial $error("rom_rp_array: unsupported configuration");
    end
  endgenerate

  always_comb begin
    a32                = '0;
    a32[ADDR_W-1:0]    = word_addr;
    word               = mix_word(a32);
  end

endmodule

// File: rtl/rom_rp_steer.sv
module rom_rp_steer
  import rom_rp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word,
  input  logic              sel_hi,
  input  logic              word_mode,
  input  logic              hole,
  input  logic              ce_n,
  input  logic              oe_n,
  output lane_out_t         nxt
);

  localparam int HALF = WORD_W / 2;

  logic read_ok;

  always_comb begin
    read_ok     = ~ce_n & ~oe_n & ~hole;
    nxt.standby = ce_n;
    nxt.lo_en   = read_ok;
    nxt.hi_en   = read_ok & word_mode;
    nxt.b15_en  = read_ok & word_mode;
    nxt.lo      = sel_hi ? word[WORD_W-1:HALF] : word[HALF-1:0];
    nxt.hi      = word[WORD_W-2:HALF];
    nxt.b15     = word[WORD_W-1];
  end

endmodule

// File: rtl/rom_rp_top.sv
module rom_rp_top
  import rom_rp_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              a_m1_in,
  output logic [7:0]        dlo_o,
  output logic              dlo_oe,
  output logic [6:0]        dhi_o,
  output logic              dhi_oe,
  output logic              d15_o,
  output logic              d15_oe,
  output logic              standby
);

  localparam int WORD_W = 16;

  // Reset synchronizer: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [ADDR_W-1:0] word_addr;
  logic              hole;
  logic              sel_hi;
  logic [WORD_W-1:0] word;
  lane_out_t         nxt;

  rom_rp_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr      (addr),
    .a_m1      (a_m1_in),
    .word_mode (word_mode),
    .word_addr (word_addr),
    .hole      (hole),
    .sel_hi    (sel_hi)
  );

  rom_rp_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .word_addr (word_addr),
    .word      (word)
  );

  rom_rp_steer #(.WORD_W(WORD_W)) u_steer (
    .word      (word),
    .sel_hi    (sel_hi),
    .word_mode (word_mode),
    .hole      (hole),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .nxt       (nxt)
  );

  // Output registers: flags every cycle, data only when a lane will be driven.
  logic       sb_q, lo_en_q, hi_en_q, b15_en_q;
  logic [7:0] lo_q;
  logic [6:0] hi_q;
  logic       b15_q;
  logic       data_ld;

  always_comb data_ld = nxt.lo_en;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sb_q     <= 1'b1;
      lo_en_q  <= 1'b0;
      hi_en_q  <= 1'b0;
      b15_en_q <= 1'b0;
    end else begin
      sb_q     <= nxt.standby;
      lo_en_q  <= nxt.lo_en;
      hi_en_q  <= nxt.hi_en;
      b15_en_q <= nxt.b15_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lo_q  <= '0;
      hi_q  <= '0;
      b15_q <= 1'b0;
    end else if (data_ld) begin
      lo_q  <= nxt.lo;
      hi_q  <= nxt.hi;
      b15_q <= nxt.b15;
    end
  end

  assign standby = sb_q;
  assign dlo_oe  = lo_en_q;
  assign dhi_oe  = hi_en_q;
  assign d15_oe  = b15_en_q;
  assign dlo_o   = lo_q;
  assign dhi_o   = hi_q;
  assign d15_o   = b15_q;

  // R4: standby silences every lane
  p_standby_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    ce_n |=> (standby && !dlo_oe && !dhi_oe && !d15_oe));

  // R5: output-enable high silences lanes, part stays operating
  p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ce_n && oe_n) |=> (!standby && !dlo_oe && !dhi_oe && !d15_oe));

  // R6: unpopulated region yields no driven lane
  p_hole_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ce_n && addr[ADDR_W-1] && addr[ADDR_W-2]) |=> (!dlo_oe && !dhi_oe && !d15_oe));

  // R2 / R3: byte mode never drives the high lane or the shared pin
  p_byte_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !word_mode |=> (!dhi_oe && !d15_oe));

  // R1: the high lane and bit 15 are only driven together with the low lane
  p_word_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dhi_oe || d15_oe) |-> (dlo_oe && dhi_oe && d15_oe && !standby));

  // R7: driven data is held while nothing is loaded
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!nxt.lo_en) |=> $stable({lo_q, hi_q, b15_q}));

endmodule

// File: tb/rom_rp_top_bench.sv
module rom_rp_top_bench;

  localparam int AW = 6;
  localparam int NWORD = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, word_mode, a_m1_in;
  logic [AW-1:0] addr;
  logic [7:0]    dlo_o;
  logic [6:0]    dhi_o;
  logic          dlo_oe, dhi_oe, d15_o, d15_oe, standby;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  rom_rp_top #(.ADDR_W(AW)) u_rom_rp_top (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .word_mode(word_mode), .addr(addr), .a_m1_in(a_m1_in),
    .dlo_o(dlo_o), .dlo_oe(dlo_oe), .dhi_o(dhi_o), .dhi_oe(dhi_oe),
    .d15_o(d15_o), .d15_oe(d15_oe), .standby(standby)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // R9 content formula, computed independently
  function automatic logic [15:0] exp_word(input int a);
    logic [31:0] h;
    h = 32'(a) * 32'h9E3779B1;
    return h[31:16] ^ h[15:0];
  endfunction

  // Compares enables and standby always, data only on lanes expected driven.
  task automatic expect_out(input string req, input bit elo, input bit ehi,
                            input bit e15, input bit esb, input logic [7:0] lo,
                            input logic [6:0] hi, input logic b15);
    logic [19:0] act, exp;
    act = {dlo_oe, dhi_oe, d15_oe, standby,
           elo ? dlo_o : 8'h00, ehi ? dhi_o : 7'h00, e15 ? d15_o : 1'b0};
    exp = {elo, ehi, e15, esb, elo ? lo : 8'h00, ehi ? hi : 7'h00, e15 ? b15 : 1'b0};
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit c, input bit o, input bit m, input int a, input bit s);
    ce_n = c; oe_n = o; word_mode = m; addr = AW'(a); a_m1_in = s;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] w;
    bit hole;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 5, 1'b0);
    repeat (3) step();
    // R8: reset state while in reset, even with a read requested
    expect_out("R8", 0, 0, 0, 1, 8'h00, 7'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R8", 0, 0, 0, 1, 8'h00, 7'h00, 1'b0);
    repeat (3) step();

    // R1 / R6 / R9: word mode sweep, a_m1_in toggled to show it is ignored
    for (int a = 0; a < NWORD; a++) begin
      drive(1'b0, 1'b0, 1'b1, a, a[0] ^ 1'b1);
      step();
      w = exp_word(a);
      hole = (a >= (NWORD * 3) / 4);
      if (hole) expect_out("R6", 0, 0, 0, 0, 8'h00, 7'h00, 1'b0);
      else      expect_out("R1", 1, 1, 1, 0, w[7:0], w[14:8], w[15]);
    end

    // R2 / R3 / R6: byte mode sweep, both byte selects
    for (int a = 0; a < NWORD; a++) begin
      for (int s = 0; s < 2; s++) begin
        drive(1'b0, 1'b0, 1'b0, a, s[0]);
        step();
        w = exp_word(a);
        hole = (a >= (NWORD * 3) / 4);
        if (hole)       expect_out("R6", 0, 0, 0, 0, 8'h00, 7'h00, 1'b0);
        else if (s == 0) expect_out("R2", 1, 0, 0, 0, w[7:0], 7'h00, 1'b0);
        else            expect_out("R3", 1, 0, 0, 0, w[15:8], 7'h00, 1'b0);
      end
    end

    // R4: standby across modes and output-enable values
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, k[0], k[1], k * 7, k[2]);
      step();
      expect_out("R4", 0, 0, 0, 1, 8'h00, 7'h00, 1'b0);
    end

    // R5: output disabled while operating
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 1'b1, k[0], k * 9 + 2, k[1]);
      step();
      expect_out("R5", 0, 0, 0, 0, 8'h00, 7'h00, 1'b0);
    end

    // R7: one-cycle latency; old result stays until the next edge
    drive(1'b0, 1'b0, 1'b1, 10, 1'b0);
    step();
    w = exp_word(10);
    drive(1'b0, 1'b0, 1'b1, 33, 1'b0);
    #1;
    expect_out("R7", 1, 1, 1, 0, w[7:0], w[14:8], w[15]);
    step();
    w = exp_word(33);
    expect_out("R7", 1, 1, 1, 0, w[7:0], w[14:8], w[15]);
    drive(1'b1, 1'b0, 1'b1, 33, 1'b0);
    #1;
    expect_out("R7", 1, 1, 1, 0, w[7:0], w[14:8], w[15]);
    step();
    expect_out("R4", 0, 0, 0, 1, 8'h00, 7'h00, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule